// File: doc/BRIEF.md
# Configurable PCM Serial Audio Transmitter

This block turns stereo PCM sample pairs into a three-wire serial stream for an external DAC: a bit clock, a left/right word clock and one serial data line. All three are produced from the block's own clock, which is the oversampling clock. A programmable divider sets how many oversampling-clock cycles each bit-clock phase lasts. The word clock and data change on the falling bit-clock edge, so the DAC samples them on the rising edge.

Each word-clock period is one frame that carries one left and one right sample. Samples are 24 bits wide at the input, and the block sends their upper 16, 18, 20 or 24 bits. Configuration inputs choose the precision, the bit order, the word-clock polarity and the channel routing. All of them are sampled once per frame, at the frame boundary. Sample pairs enter through a one-entry valid/ready holding stage. When no new pair is waiting at a frame boundary, the last pair is sent again and an underrun flag is raised for that frame.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held, `bclk`, `ws`, `sdo` and `underrun` are low and `in_ready` is high.
- R2: Each high or low phase of `bclk` lasts `cfg_div`+1 clock cycles.
- R3: A frame has 32 bit-clock slots when the precision code is 00 and 64 slots otherwise. `ws` is low in the first half (the left channel) and high in the second half when polarity is not inverted. `ws` and `sdo` change only in the cycle in which `bclk` falls.
- R4: Precision code 00/01/10/11 sends 16/18/20/24 bits, taken as the top bits of the 24-bit input sample. In 16-bit mode the bits fill slots 0 to 15 of each half. In the other modes they fill slots 1 to W of each 32-slot half, and every remaining slot carries 0.
- R5: With `cfg_lsb_first` at 0 the most significant sent bit comes first. With it at 1 the least significant sent bit comes first.
- R6: With `cfg_ws_inv` at 1, `ws` is high for the left half and low for the right half.
- R7: Routing code 00 sends left then right, 01 sends left in both halves, 10 sends right in both halves, and 11 sends right in the left half and left in the right half.
- R8: One pair is held at a time. `in_ready` is low from the cycle after an accepted pair until that pair moves into the active frame. A pair moves at the falling bit-clock edge that starts a frame's last slot, and the next frame sends it.
- R9: If no pair is held at that moment, the next frame repeats the previous pair and `underrun` is high for that frame. Otherwise `underrun` is low for it.
- R10: Precision, bit order, polarity and routing are sampled only at that same moment, so a change in mid-frame does not alter the length or content of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Bit-clock phase length minus one, in clock cycles |
| cfg_prec | input | 2 | Precision code |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_ws_inv | input | 1 | Word-clock polarity inversion |
| cfg_route | input | 2 | Channel routing code |
| in_valid | input | 1 | Sample pair valid |
| in_left | input | 24 | Left sample, MSB-justified |
| in_right | input | 24 | Right sample, MSB-justified |
| in_ready | output | 1 | Holding stage empty |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word clock |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
Every output is registered, so `bclk`, `ws`, `sdo` and `underrun` all change one clock edge after the cycle that causes them. The bench samples on falling clock edges, half a cycle later. It detects a falling bit clock by comparing successive samples. At each falling bit clock it checks that slot's expected `ws` and `sdo`, and at each frame-ending slot it checks `underrun`. An accepted pair is stamped with the clock edge that took it. The pair counts for the next frame only if that edge comes strictly before the frame-ending edge, which matches the one-cycle lag of the holding stage.

// File: rtl/pcm_serial_tx.sv
`timescale 1ns/1ps
module pcm_serial_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_prec,
  input  logic             cfg_lsb_first,
  input  logic             cfg_ws_inv,
  input  logic [1:0]       cfg_route,
  input  logic             in_valid,
  input  logic [23:0]      in_left,
  input  logic [23:0]      in_right,
  output logic             in_ready,
  output logic             bclk,
  output logic             ws,
  output logic             sdo,
  output logic             underrun
);

  logic [DIV_W-1:0] cnt;
  logic             bclk_q, ws_q, sdo_q, underrun_q;
  logic [5:0]       slot, nslot, last_idx, pos, k, w6;
  logic             last_q;
  logic [1:0]       prec_q, route_q;
  logic             lsb_q, inv_q;
  logic [23:0]      act_l, act_r, pend_l, pend_r, l_out, r_out, smp;
  logic             pend_full;
  logic             tick, fall, load, mode16, right, in_rng, nbit;
  logic [4:0]       idx;

  assign tick     = (cnt >= cfg_div);
  assign fall     = tick & bclk_q;
  assign mode16   = (prec_q == 2'd0);
  assign last_idx = mode16 ? 6'd31 : 6'd63;
  assign nslot    = last_q ? 6'd0 : slot + 6'd1;
  assign load     = fall && (nslot == last_idx);

  assign right = mode16 ? nslot[4] : nslot[5];
  assign pos   = mode16 ? {2'b00, nslot[3:0]} : {1'b0, nslot[4:0]};
  assign k     = mode16 ? pos : pos - 6'd1;

  always_comb begin
    case (prec_q)
      2'd0:    w6 = 6'd16;
      2'd1:    w6 = 6'd18;
      2'd2:    w6 = 6'd20;
      default: w6 = 6'd24;
    endcase
  end

  assign l_out = (route_q == 2'd2 || route_q == 2'd3) ? act_r : act_l;
  assign r_out = (route_q == 2'd1 || route_q == 2'd3) ? act_l : act_r;
  assign smp   = right ? r_out : l_out;

  assign in_rng = mode16 || (pos != 6'd0 && pos <= w6);
  assign idx    = lsb_q ? 5'(6'd24 - w6 + k) : 5'(6'd23 - k);
  assign nbit   = in_rng ? smp[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      bclk_q     <= 1'b0;
      slot       <= 6'd30;
      last_q     <= 1'b0;
      ws_q       <= 1'b0;
      sdo_q      <= 1'b0;
      prec_q     <= 2'd0;
      route_q    <= 2'd0;
      lsb_q      <= 1'b0;
      inv_q      <= 1'b0;
      act_l      <= '0;
      act_r      <= '0;
      pend_l     <= '0;
      pend_r     <= '0;
      pend_full  <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      if (tick) begin
        cnt    <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
      if (fall) begin
        slot   <= nslot;
        last_q <= (nslot == last_idx);
        ws_q   <= right ^ inv_q;
        sdo_q  <= nbit;
      end
      if (load) begin
        prec_q     <= cfg_prec;
        route_q    <= cfg_route;
        lsb_q      <= cfg_lsb_first;
        inv_q      <= cfg_ws_inv;
        underrun_q <= !pend_full;
        if (pend_full) begin
          act_l <= pend_l;
          act_r <= pend_r;
        end
      end
      if (in_valid && !pend_full) begin
        pend_l    <= in_left;
        pend_r    <= in_right;
        pend_full <= 1'b1;
      end else if (load) begin
        pend_full <= 1'b0;
      end
    end
  end

  assign in_ready = !pend_full;
  assign bclk     = bclk_q;
  assign ws       = ws_q;
  assign sdo      = sdo_q;
  assign underrun = underrun_q;

  a_r3_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_q) |-> $fell(bclk_q));

  a_r3_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $fell(bclk_q));

  a_r4_pad_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !mode16 && pos == 6'd0) |=> !sdo_q);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(underrun_q) |-> $fell(bclk_q));

endmodule

// File: tb/pcm_serial_tx_test.sv
`timescale 1ns/1ps
module pcm_serial_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [1:0]  cfg_prec = 2'd0;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_ws_inv = 1'b0;
  logic [1:0]  cfg_route = 2'd0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        in_ready, bclk, ws, sdo, underrun;

  pcm_serial_tx #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_prec(cfg_prec),
    .cfg_lsb_first(cfg_lsb_first), .cfg_ws_inv(cfg_ws_inv), .cfg_route(cfg_route),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .in_ready(in_ready), .bclk(bclk), .ws(ws), .sdo(sdo), .underrun(underrun)
  );

  always #10 clk = ~clk;

  int    checks = 0, errors = 0;
  longint cyc = 0;
  bit    ended = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  typedef struct { logic [23:0] l; logic [23:0] r; longint c; } pair_t;
  pair_t q[$];

  function automatic logic exp_sdo(input logic [1:0] prec, input logic lsb,
      input logic [1:0] rt, input logic [23:0] l, input logic [23:0] r, input int s);
    int fr = (prec == 0) ? 32 : 64;
    int half = fr / 2;
    int w = (prec == 0) ? 16 : (prec == 1) ? 18 : (prec == 2) ? 20 : 24;
    int p = s % half;
    int kk = (prec == 0) ? p : p - 1;
    logic [23:0] v;
    if (s >= half) v = (rt == 1 || rt == 3) ? l : r;
    else           v = (rt == 2 || rt == 3) ? r : l;
    if (kk < 0 || kk >= w) return 1'b0;
    return lsb ? v[24 - w + kk] : v[23 - kk];
  endfunction

  bit mon_on = 0;
  logic [1:0] m_prec = 0, m_route = 0;
  logic m_lsb = 0, m_inv = 0;
  logic [23:0] m_l = 0, m_r = 0;
  int bslot = 30, run = 0, skip = 1, frame_cnt = 0, last_len = 0, prev_fr = 32;
  bit blast = 0, bad_chg = 0, first_frame = 1;
  logic prev_bclk = 0, prev_ws = 0, prev_sdo = 0;
  event frame_ev;

  task automatic do_fall();
    int fr = (m_prec == 0) ? 32 : 64;
    int ns = blast ? 0 : bslot + 1;
    logic ew, es, eu;
    string lbl;
    ew = ((ns >= fr / 2) ? 1'b1 : 1'b0) ^ m_inv;
    es = exp_sdo(m_prec, m_lsb, m_route, m_l, m_r, ns);
    chk(ws == ew, m_inv ? "R6" : "R3", $sformatf("ws slot %0d", ns), ws, ew);
    lbl = (m_route != 0) ? "R7" : (m_lsb ? "R5" : "R4");
    chk(sdo == es, lbl, $sformatf("sdo slot %0d prec %0d", ns, m_prec), sdo, es);
    chk(!bad_chg, "R3", "ws/sdo moved off a falling bclk", bad_chg, 0);
    bad_chg = 0;
    if (ns == 0) begin
      last_len = frame_cnt;
      if (!first_frame) chk(frame_cnt == prev_fr, "R3", "frame length", frame_cnt, prev_fr);
      first_frame = 0;
      frame_cnt = 0;
    end
    frame_cnt++;
    bslot = ns;
    blast = (ns == fr - 1);
    if (ns == fr - 1) begin
      prev_fr = fr;
      m_prec = cfg_prec; m_lsb = cfg_lsb_first; m_inv = cfg_ws_inv; m_route = cfg_route;
      if (q.size() > 0 && q[0].c < cyc) begin
        m_l = q[0].l; m_r = q[0].r; void'(q.pop_front()); eu = 0;
      end else eu = 1;
      chk(underrun == eu, "R9", "underrun flag", underrun, eu);
    end
    if (ns == 0) ->frame_ev;
  endtask

  always @(negedge clk) if (mon_on) begin
    if (bclk != prev_bclk) begin
      if (skip > 0) skip--;
      else chk(run + 1 == int'(cfg_div) + 1, "R2", "bclk phase length", run + 1, cfg_div + 1);
      run = 0;
      if (prev_bclk && !bclk) do_fall();
      else if (ws != prev_ws || sdo != prev_sdo) bad_chg = 1;
    end else begin
      run++;
      if (ws != prev_ws || sdo != prev_sdo) bad_chg = 1;
    end
    prev_bclk = bclk; prev_ws = ws; prev_sdo = sdo;
  end

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_valid = 1; in_left = l; in_right = r;
    while (!in_ready) @(negedge clk);
    q.push_back('{l, r, cyc + 1});
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(bclk == 0, "R1", "bclk in reset", bclk, 0);
    chk(ws == 0, "R1", "ws in reset", ws, 0);
    chk(sdo == 0, "R1", "sdo in reset", sdo, 0);
    chk(underrun == 0, "R1", "underrun in reset", underrun, 0);
    chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1;
    mon_on = 1;
    push(24'hA5C3F1, 24'h3C0F81);
    chk(in_ready == 0, "R8", "in_ready after accept", in_ready, 0);

    for (int i = 0; i < 44; i++) begin
      logic [23:0] l, r;
      @(frame_ev);
      cfg_prec = 2'(i % 4);
      cfg_lsb_first = (i < 8) ? 1'(i / 4) : 1'($urandom);
      cfg_ws_inv = (i < 16) ? 1'(i / 8) : 1'($urandom);
      cfg_route = (i >= 16 && i < 20) ? 2'(i - 16) : 2'($urandom);
      if (i % 9 == 5) begin
        cfg_div = 8'($urandom % 3);
        skip = 2;
      end
      case (i % 6)
        0: begin l = 24'h800001; r = 24'hFFFFFF; end
        1: begin l = 24'h000000; r = 24'h7FFFFE; end
        default: begin l = 24'($urandom); r = 24'($urandom); end
      endcase
      if (i % 7 != 3) push(l, r);
      if (i % 5 == 1) push(24'($urandom), 24'($urandom));
    end

    @(frame_ev);
    cfg_prec = 0; cfg_div = 8'd1; skip = 2;
    push(24'h123456, 24'hFEDCBA);
    @(frame_ev);
    repeat (20) @(negedge clk);
    cfg_prec = 2'd3;
    @(frame_ev);
    chk(last_len == 32, "R10", "frame length after mid-frame change", last_len, 32);
    @(frame_ev);
    chk(last_len == 64, "R10", "frame length in next frame", last_len, 64);
    @(frame_ev);
    finish_run();
  end
endmodule